// File: doc/BRIEF.md
# Configuration Shadow Mismatch Reset Monitor

This block guards a bank of configuration registers against random bit upsets, such as those caused by electrostatic discharge. Each configuration register has a partner shadow register that holds its bitwise inverse. While the chip runs normally, every pair is compared on every clock. If any pair stops being exact complements, the block raises a device reset request.

During the restart that follows, the block reads each configuration word in turn from a non-volatile memory model. It writes the word into the configuration register and its inverse into the shadow register. The same restart and reload take place when any other hard reset cause is signalled.

An 8-bit reset-cause status register holds a sticky active-low mismatch flag at bit 5. A mismatch reset clears the flag. Other reset causes leave it unchanged, and software sets it again by writing. A separate read-only output gives the index of the lowest-numbered register pair that mismatched.

Top module: `cfg_shadow_monitor`

## Requirements
- R1: While monitoring, any pair whose configuration and shadow words are not exact bitwise complements causes `rst_req` to go high at the first clock edge after the corruption becomes visible, however long the block has been running.
- R2: After every reload, `cfg_q` holds exactly the words supplied on `nvm_data`, with register i in bits [i*W +: W]. The shadows hold their inverses, so no further reset follows while no corruption is injected.
- R3: A mismatch reset makes `stat_rdata` read 8'h00: bit 5 (the mismatch flag) is 0 and all other bits are always 0.
- R4: A pulse on any bit of `hard_rst_in` starts the same reset request and reload, and leaves bit 5 of `stat_rdata` at whatever value it held before.
- R5: A write with `stat_wr` and `stat_wdata` equal to 8'h20 sets bit 5 to 1. A write with bit 5 at 0, or with any other bit at 1, has no effect.
- R6: While `rst_n` is low, `rst_req` is high and `stat_rdata` reads 8'h20. After `rst_n` is released, a full reload runs before `rst_req` falls.
- R7: A mismatch or hard-reset trigger holds `rst_req` high for exactly 16 clock cycles when the reload fits inside that window.
- R8: A reload drives `nvm_rd` high for NREG consecutive cycles, with `nvm_addr` stepping from 0 up to NREG-1. `nvm_data` is sampled in the same cycle.
- R9: Comparison is off from the first reload cycle until one cycle after the last. Corruption of a word that is then reloaded causes no further reset. Corruption of a word that is already reloaded triggers a new reset two cycles after the last reload cycle.
- R10: `first_idx` reports the lowest index among the pairs that mismatched in the triggering cycle. It holds that value until the next mismatch reset, and hard resets do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| nvm_rd | output | 1 | Reload read strobe to the memory model |
| nvm_addr | output | IW | Index of the configuration word being reloaded |
| nvm_data | input | W | Word returned by the memory model in the same cycle |
| inj_en | input | NREG | Upset model: one bit per register pair selects the pairs to corrupt |
| inj_shadow | input | 1 | Upset model: 1 corrupts the shadow word, 0 the configuration word |
| inj_mask | input | W | Upset model: bits to invert |
| hard_rst_in | input | NCAUSE | Other hard reset causes, one bit each |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status register write data |
| stat_rdata | output | 8 | Status register read value, mismatch flag at bit 5 |
| first_idx | output | IW | Lowest mismatching register index from the last mismatch reset |
| rst_req | output | 1 | Device reset request |
| cfg_q | output | NREG*W | Current configuration words, flattened |

## Verification
A wrong shadow value or a missed reload write shows up as an unexpected rise of `rst_req` within two cycles of comparison resuming. It also shows up at once as a `cfg_q` word differing from the memory model. A hold counter that is off by one changes the measured request width by a cycle. A comparison window that reopens a cycle early or late moves the retrigger in the resumption test, so the total request length differs from 26 cycles. A flag that reacts to the wrong cause is read out through `stat_rdata` in the cycle after the request ends.

// File: rtl/cmrm_pkg.sv
// Shared definitions for the configuration shadow mismatch monitor.
package cmrm_pkg;
    // Restart sequencer states: reloading words, one guard cycle, monitoring.
    typedef enum logic [1:0] {
        SEQ_LOAD  = 2'd0,
        SEQ_GUARD = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_t;

    localparam int STAT_W   = 8;
    localparam int FLAG_POS = 5;
endpackage

// File: rtl/cmrm_cfg_bank.sv
// Configuration and shadow register bank.
// Holds NREG configuration words and their complement shadows. A reload write
// stores a word and its inverse. The upset inputs model random bit flips.
// Assumes ld_addr < NREG whenever ld_en is high.
module cmrm_cfg_bank #(
    parameter int NREG = 8,
    parameter int W    = 8,
    parameter int IW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IW-1:0]     ld_addr,
    input  logic [W-1:0]      ld_data,
    input  logic [NREG-1:0]   inj_en,
    input  logic              inj_shadow,
    input  logic [W-1:0]      inj_mask,
    output logic [NREG*W-1:0] cfg_flat,
    output logic [NREG*W-1:0] sh_flat
);
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_pair
            logic [W-1:0] c_q;
            logic [W-1:0] s_q;
            // Pair storage: reload has priority over an injected upset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    c_q <= '0;
                    s_q <= '1;
                end else if (ld_en && ld_addr == IW'(g)) begin
                    c_q <= ld_data;
                    s_q <= ~ld_data;
                end else if (inj_en[g]) begin
                    if (inj_shadow) s_q <= s_q ^ inj_mask;
                    else            c_q <= c_q ^ inj_mask;
                end
            end
            assign cfg_flat[g*W +: W] = c_q;
            assign sh_flat[g*W +: W]  = s_q;
        end
    endgenerate

    // R2: a freshly reloaded pair is a complementary pair.
    p_reload_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> ((cfg_flat[$past(ld_addr)*W +: W] ^ sh_flat[$past(ld_addr)*W +: W]) == {W{1'b1}}));
endmodule

// File: rtl/cmrm_compare.sv
// Pair comparator.
// Flags every pair whose words are not exact complements and reports the
// lowest such index. Purely combinational; gating is done by the sequencer.
module cmrm_compare #(
    parameter int NREG = 8,
    parameter int W    = 8,
    parameter int IW   = 3
) (
    input  logic [NREG*W-1:0] cfg_flat,
    input  logic [NREG*W-1:0] sh_flat,
    output logic              any_bad,
    output logic [IW-1:0]     low_idx
);
    logic [NREG-1:0] bad;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_cmp
            assign bad[g] = (cfg_flat[g*W +: W] ^ sh_flat[g*W +: W]) != {W{1'b1}};
        end
    endgenerate

    // Priority pick: scanning downward leaves the lowest bad index.
    always_comb begin
        low_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (bad[i]) low_idx = IW'(i);
        end
    end

    assign any_bad = |bad;
endmodule

// File: rtl/cmrm_restart_seq.sv
// Restart sequencer.
// Walks the reload addresses, keeps comparison off during the reload and one
// guard cycle after it, and shapes the reset request to HOLD cycles minimum.
// Assumes HOLD >= 2. Power-on reset starts a reload directly.
module cmrm_restart_seq
    import cmrm_pkg::*;
#(
    parameter int NREG = 8,
    parameter int IW   = 3,
    parameter int HOLD = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mm_hit,
    input  logic          ext_hit,
    output logic          cmp_en,
    output logic          mm_take,
    output logic          rd_en,
    output logic [IW-1:0] rd_addr,
    output logic          rst_req
);
    localparam int CW = $clog2(HOLD);

    seq_state_t    state_q;
    logic [IW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          start;

    assign cmp_en  = (state_q == SEQ_RUN);
    assign mm_take = cmp_en && mm_hit;
    assign start   = cmp_en && (mm_hit || ext_hit);
    assign rd_en   = (state_q == SEQ_LOAD);
    assign rd_addr = addr_q;

    // Reload walk: ascending addresses, then a guard cycle, then monitoring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_LOAD;
            addr_q  <= '0;
        end else begin
            unique case (state_q)
                SEQ_LOAD: begin
                    if (addr_q == IW'(NREG - 1)) begin
                        state_q <= SEQ_GUARD;
                        addr_q  <= '0;
                    end else begin
                        addr_q  <= addr_q + 1'b1;
                    end
                end
                SEQ_GUARD: state_q <= SEQ_RUN;
                SEQ_RUN: if (start) begin
                    state_q <= SEQ_LOAD;
                    addr_q  <= '0;
                end
                default: state_q <= SEQ_LOAD;
            endcase
        end
    end

    // Request shaping: restart the hold window on every trigger; drop only
    // once the window has run out and no reload is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b1;
            cnt_q   <= CW'(HOLD - 1);
        end else if (start) begin
            rst_req <= 1'b1;
            cnt_q   <= CW'(HOLD - 1);
        end else if (rst_req) begin
            if (cnt_q != '0)               cnt_q   <= cnt_q - 1'b1;
            else if (state_q != SEQ_LOAD)  rst_req <= 1'b0;
        end
    end

    // R7: the request cannot drop while hold cycles remain.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && cnt_q != '0) |=> rst_req);
    // R8: reload reads happen only under a reset request.
    p_read_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rst_req);
    // R8: a new reload starts at address 0.
    p_walk_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> rd_addr == '0);
    // R9: no reload read while comparison is live.
    p_no_cmp_in_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !mm_take);
endmodule

// File: rtl/cfg_shadow_monitor.sv
// Configuration shadow mismatch reset monitor (top).
// Ties the pair bank, comparator and restart sequencer together, and owns the
// reset-cause status register (active-low mismatch flag at FLAG_POS) and the
// first-mismatch index. Synchronous active-low reset acts as power-on reset.
module cfg_shadow_monitor
    import cmrm_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int W      = 8,
    parameter int HOLD   = 16,
    parameter int NCAUSE = 4,
    localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              nvm_rd,
    output logic [IW-1:0]     nvm_addr,
    input  logic [W-1:0]      nvm_data,
    input  logic [NREG-1:0]   inj_en,
    input  logic              inj_shadow,
    input  logic [W-1:0]      inj_mask,
    input  logic [NCAUSE-1:0] hard_rst_in,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] stat_rdata,
    output logic [IW-1:0]     first_idx,
    output logic              rst_req,
    output logic [NREG*W-1:0] cfg_q
);
    localparam logic [STAT_W-1:0] FLAG_MASK = STAT_W'(1) << FLAG_POS;

    logic [NREG*W-1:0] sh_flat;
    logic              mm_hit;
    logic [IW-1:0]     low_idx;
    logic              cmp_en;
    logic              mm_take;
    logic              flag_q;
    logic [IW-1:0]     idx_q;
    logic              sw_set;

    cmrm_cfg_bank #(.NREG(NREG), .W(W), .IW(IW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (nvm_rd),
        .ld_addr    (nvm_addr),
        .ld_data    (nvm_data),
        .inj_en     (inj_en),
        .inj_shadow (inj_shadow),
        .inj_mask   (inj_mask),
        .cfg_flat   (cfg_q),
        .sh_flat    (sh_flat)
    );

    cmrm_compare #(.NREG(NREG), .W(W), .IW(IW)) u_cmp (
        .cfg_flat (cfg_q),
        .sh_flat  (sh_flat),
        .any_bad  (mm_hit),
        .low_idx  (low_idx)
    );

    cmrm_restart_seq #(.NREG(NREG), .IW(IW), .HOLD(HOLD)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mm_hit  (mm_hit),
        .ext_hit (|hard_rst_in),
        .cmp_en  (cmp_en),
        .mm_take (mm_take),
        .rd_en   (nvm_rd),
        .rd_addr (nvm_addr),
        .rst_req (rst_req)
    );

    // A status write counts only when it is exactly the flag bit.
    assign sw_set = stat_wr && (stat_wdata == FLAG_MASK);

    // Sticky active-low flag: mismatch clears, software write sets.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b1;
        else if (mm_take) flag_q <= 1'b0;
        else if (sw_set)  flag_q <= 1'b1;
    end

    // First-mismatch index, captured only when a mismatch reset is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (mm_take) idx_q <= low_idx;
    end

    assign stat_rdata = flag_q ? FLAG_MASK : '0;
    assign first_idx  = idx_q;

    // R3: the flag falls only together with a reset request.
    p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> rst_req);
    // R5: the flag rises only after a valid software write.
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(stat_wr && stat_wdata == FLAG_MASK));
    // R4: a hard reset alone leaves the flag where it was.
    p_hard_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && (|hard_rst_in) && !mm_hit && !stat_wr) |=> flag_q == $past(flag_q));
    // R1: a live mismatch always raises the request.
    p_mm_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && mm_hit) |=> rst_req);
endmodule

// File: tb/tb_cfg_shadow_monitor.sv
module tb_cfg_shadow_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;
    localparam int W    = 8;
    localparam int NC   = 4;
    localparam int IW   = 3;

    typedef struct {
        int           addr;
        logic [W-1:0] data;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              nvm_rd;
    logic [IW-1:0]     nvm_addr;
    logic [W-1:0]      nvm_data;
    logic [NREG-1:0]   inj_en = '0;
    logic              inj_shadow = 1'b0;
    logic [W-1:0]      inj_mask = '0;
    logic [NC-1:0]     hard_rst_in = '0;
    logic              stat_wr = 1'b0;
    logic [7:0]        stat_wdata = '0;
    logic [7:0]        stat_rdata;
    logic [IW-1:0]     first_idx;
    logic              rst_req;
    logic [NREG*W-1:0] cfg_q;

    logic [W-1:0] nvm [NREG];
    exp_t         exp_q[$];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign nvm_data = nvm[nvm_addr];

    cfg_shadow_monitor #(.NREG(NREG), .W(W), .HOLD(16), .NCAUSE(NC)) dut (
        .clk(clk), .rst_n(rst_n), .nvm_rd(nvm_rd), .nvm_addr(nvm_addr),
        .nvm_data(nvm_data), .inj_en(inj_en), .inj_shadow(inj_shadow),
        .inj_mask(inj_mask), .hard_rst_in(hard_rst_in), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .first_idx(first_idx),
        .rst_req(rst_req), .cfg_q(cfg_q)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NREG*W-1:0] nvm_flat();
        logic [NREG*W-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*W +: W] = nvm[i];
        return f;
    endfunction

    // Driver side of the scoreboard: one expected read per register.
    task automatic expect_reload();
        for (int i = 0; i < NREG; i++) begin
            exp_t e;
            e.addr = i;
            e.data = nvm[i];
            exp_q.push_back(e);
        end
    endtask

    // Monitor: pops one item per reload read, then checks the stored word.
    int           p_addr;
    logic [W-1:0] p_data;
    bit           pend = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                chk("R2 reloaded word", 64'(cfg_q[p_addr*W +: W]), 64'(p_data));
                pend = 1'b0;
            end
            if (nvm_rd) begin
                if (exp_q.size() == 0) begin
                    chk("R9 unexpected reload read", 64'(nvm_addr), 64'hFFFF);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk("R8 reload address order", 64'(nvm_addr), 64'(e.addr));
                    p_addr = e.addr;
                    p_data = e.data;
                    pend   = 1'b1;
                end
            end
        end
    end

    // Counts negedges with rst_req high, starting at the current negedge.
    task automatic count_req(output int n);
        n = 0;
        while (rst_req && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic hard_pulse(int bit_i);
        @(negedge clk);
        hard_rst_in[bit_i] = 1'b1;
        @(negedge clk);
        hard_rst_in = '0;
    endtask

    task automatic stat_write(logic [7:0] v);
        @(negedge clk);
        stat_wr = 1'b1;
        stat_wdata = v;
        @(negedge clk);
        stat_wr = 1'b0;
        stat_wdata = '0;
    endtask

    task automatic new_image(logic [W-1:0] k);
        for (int i = 0; i < NREG; i++) nvm[i] = W'(k + W'(i * 29));
    endtask

    bit done = 1'b0;
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        new_image(8'h3C);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6 request high in reset", 64'(rst_req), 64'd1);
        chk("R6 flag set at power-on", 64'(stat_rdata), 64'h20);
        expect_reload();
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        count_req(n);
        chk("R6 reload done after power-on", 64'(exp_q.size()), 64'd0);
        chk("R2 image after power-on", 64'(cfg_q), 64'(nvm_flat()));
        chk("R6 flag after power-on", 64'(stat_rdata), 64'h20);
        repeat (12) @(negedge clk);
        chk("R2 no spurious reset", 64'(rst_req), 64'd0);

        // Single bit upset in a configuration word, long after start.
        new_image(8'hA5);
        expect_reload();
        repeat (30) @(negedge clk);
        inj_en = 8'b0000_1000; inj_shadow = 1'b0; inj_mask = 8'h01;
        @(negedge clk);
        inj_en = '0;
        chk("R1 request still low before compare edge", 64'(rst_req), 64'd0);
        @(negedge clk);
        chk("R1 request after upset", 64'(rst_req), 64'd1);
        count_req(n);
        chk("R7 request width", 64'(n), 64'd16);
        chk("R3 flag cleared", 64'(stat_rdata), 64'h00);
        chk("R10 first index", 64'(first_idx), 64'd3);
        chk("R2 image restored", 64'(cfg_q), 64'(nvm_flat()));

        // Status writes.
        stat_write(8'h21);
        @(negedge clk);
        chk("R5 write with extra bit ignored", 64'(stat_rdata), 64'h00);
        stat_write(8'h00);
        chk("R5 write of zero ignored", 64'(stat_rdata), 64'h00);
        stat_write(8'h20);
        chk("R5 flag set by write", 64'(stat_rdata), 64'h20);

        // Hard reset with flag at 1.
        new_image(8'h17);
        expect_reload();
        hard_pulse(2);
        chk("R4 request on hard reset", 64'(rst_req), 64'd1);
        count_req(n);
        chk("R7 hard reset width", 64'(n), 64'd16);
        chk("R4 flag kept at 1", 64'(stat_rdata), 64'h20);
        chk("R4 image reloaded", 64'(cfg_q), 64'(nvm_flat()));

        // Two shadows corrupted in one cycle: lowest index wins.
        new_image(8'h6E);
        expect_reload();
        repeat (3) @(negedge clk);
        inj_en = 8'b0100_0100; inj_shadow = 1'b1; inj_mask = 8'h80;
        @(negedge clk);
        inj_en = '0;
        @(negedge clk);
        count_req(n);
        chk("R10 lowest index of two", 64'(first_idx), 64'd2);
        chk("R3 flag cleared by shadow upset", 64'(stat_rdata), 64'h00);
        chk("R2 image after shadow upset", 64'(cfg_q), 64'(nvm_flat()));

        // Hard reset with flag at 0.
        new_image(8'hC1);
        expect_reload();
        hard_pulse(0);
        count_req(n);
        chk("R4 flag kept at 0", 64'(stat_rdata), 64'h00);
        chk("R10 index kept by hard reset", 64'(first_idx), 64'd2);

        // Upset of a word not yet reloaded: overwritten, no retrigger.
        new_image(8'h52);
        expect_reload();
        @(negedge clk);
        hard_rst_in[1] = 1'b1;
        @(negedge clk);
        hard_rst_in = '0;
        inj_en = 8'b1000_0000; inj_shadow = 1'b0; inj_mask = 8'h10;
        @(negedge clk);
        inj_en = '0;
        count_req(n);
        chk("R9 width with overwritten upset", 64'(n), 64'd15);
        for (int k = 0; k < 20; k++) begin
            if (rst_req) chk("R9 no retrigger", 64'(rst_req), 64'd0);
            @(negedge clk);
        end
        chk("R9 stays out of reset", 64'(rst_req), 64'd0);
        chk("R9 flag untouched", 64'(stat_rdata), 64'h00);

        // Upset of an already reloaded word: retrigger after the guard cycle.
        stat_write(8'h20);
        new_image(8'h0B);
        expect_reload();
        expect_reload();
        hard_pulse(3);
        @(negedge clk);
        @(negedge clk);
        inj_en = 8'b0000_0001; inj_shadow = 1'b0; inj_mask = 8'h04;
        @(negedge clk);
        inj_en = '0;
        count_req(n);
        chk("R9 total width with retrigger", 64'(n + 3), 64'd26);
        chk("R9 retrigger clears flag", 64'(stat_rdata), 64'h00);
        chk("R10 retrigger index", 64'(first_idx), 64'd0);
        chk("R8 both reloads consumed", 64'(exp_q.size()), 64'd0);
        chk("R2 image after retrigger", 64'(cfg_q), 64'(nvm_flat()));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule